// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block sits on the bus side of a 16-bit processor and keeps a small store of instruction bytes ready for the execution side. It holds a 16-bit fetch pointer. Whenever the six-byte queue is sure to have room, it issues single-byte code reads to a simple synchronous memory port. It does this on its own, ahead of and in parallel with the consumer draining bytes, so bus work and execution overlap.

The consumer takes bytes one at a time through a valid/ready handshake, oldest first. On a control transfer the execution side raises a one-cycle flush with a new target address. The queue is emptied, every read still in flight is marked for discard, and fetching restarts at the target.

The memory port accepts a read when request valid and ready are both high. It returns exactly one response per accepted read, in request order, at most one per cycle, and some cycles later. The block always takes a response, so that channel has no ready signal.

Top module: `instr_prefetch_queue`

## Requirements
- R1: After reset is released, byteValid is low and the first read request is presented at address 0x0000.
- R2: With the consumer stalled, the block fetches and holds exactly six bytes. It then keeps memReqValid low for as long as the queue stays full.
- R3: Bytes are delivered oldest first. Byte k after a start point (reset or flush) is the memory content at start address + k, modulo 2^16.
- R4: Fetching and draining proceed in the same cycle. With one-cycle memory latency, an always-ready memory and an always-ready consumer, at least 46 bytes are delivered in any 50 consecutive cycles once running.
- R5: One byte leaves per cycle in which byteValid and byteReady are both high at the clock edge. While byteValid is high and byteReady is low, with no flush, byteValid and byteData hold in the next cycle.
- R6: memReqValid is high only when bytes held plus all reads in flight, counting reads that will be discarded, is below six.
- R7: The request address is the fetch pointer plus the number of live reads in flight. It advances by one per accepted request and wraps from 0xFFFF to 0x0000.
- R8: A flush empties the queue, so byteValid is low in the next cycle. Responses to reads accepted before or during the flush cycle are discarded. The next request goes to the flush target.
- R9: byteValid is high exactly when the queue holds at least one byte.
- R10: In a flush cycle memReqValid is low. A consumer handshake completing in that same cycle still takes the current head byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| flushValid | input | 1 | One-cycle redirect: empty queue, restart at flushAddr |
| flushAddr | input | 16 | New fetch address for a redirect |
| memReqValid | output | 1 | Read request presented |
| memReqReady | input | 1 | Memory accepts the presented request |
| memReqAddr | output | 16 | Byte address of the read request |
| memRspValid | input | 1 | A read response is on memRspData |
| memRspData | input | 8 | Read response byte |
| byteValid | output | 1 | Head byte available to the consumer |
| byteReady | input | 1 | Consumer takes the head byte |
| byteData | output | 8 | Head byte of the queue |

## Verification
If the occupancy count drifts from the real fill level, it shows within one cycle as a byteValid value that disagrees with bytes delivered and received. It also shows as a request issued while six slots are already spoken for. A wrong discard count shows as a stale byte from the old stream, or as a missing byte after a redirect, at the first delivery following the flush. A bad fetch pointer or in-flight count shows on memReqAddr at the next request as a skipped, repeated or unwrapped address. The bench sweeps memory latency, memory ready patterns and consumer stall patterns, and redirects in each, so that these errors meet both full and empty queues.

// File: rtl/prefetch_pkg.sv
package prefetch_pkg;

  // Strobes sent from the control to the datapath each cycle.
  typedef struct packed {
    logic push;   // write memRspData into the tail slot, advance fetch pointer
    logic pop;    // advance the head slot
    logic flush;  // reset slot indices, load fetch pointer from target
  } pfStrobes_t;

endpackage

// File: rtl/prefetch_ctrl.sv
module prefetch_ctrl
  import prefetch_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flushValid,
  input  logic          memReqReady,
  input  logic          memRspValid,
  input  logic          byteReady,
  output logic          memReqValid,
  output logic          byteValid,
  output logic [CW-1:0] pendingCnt,
  output pfStrobes_t    strobes
);

  localparam logic [CW:0] DEPTH_W = (CW + 1)'(DEPTH);

  logic [CW-1:0] count;     // bytes held
  logic [CW-1:0] pending;   // live reads in flight
  logic [CW-1:0] dropCnt;   // reads in flight whose responses are discarded
  logic [CW:0]   occupancy;
  logic          issue;
  logic          rspLive;
  logic          rspDrop;
  logic          pushEn;
  logic          popEn;

  // Every slot that is held or spoken for by an outstanding read.
  assign occupancy = {1'b0, count} + {1'b0, pending} + {1'b0, dropCnt};

  assign memReqValid = !flushValid && (occupancy < DEPTH_W);
  assign issue       = memReqValid && memReqReady;
  assign byteValid   = (count != '0);
  assign popEn       = byteValid && byteReady;
  assign rspDrop     = memRspValid && (dropCnt != '0);
  assign rspLive     = memRspValid && (dropCnt == '0);
  assign pushEn      = rspLive && !flushValid;

  always_comb begin
    strobes       = '0;
    strobes.push  = pushEn;
    strobes.pop   = popEn;
    strobes.flush = flushValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      pending <= '0;
      dropCnt <= '0;
    end else if (flushValid) begin
      count   <= '0;
      pending <= '0;
      dropCnt <= dropCnt + pending - CW'(memRspValid);
    end else begin
      count   <= count + CW'(pushEn) - CW'(popEn);
      pending <= pending + CW'(issue) - CW'(rspLive);
      dropCnt <= dropCnt - CW'(rspDrop);
    end
  end

  assign pendingCnt = pending;

endmodule

// File: rtl/prefetch_dpath.sv
module prefetch_dpath
  import prefetch_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  pfStrobes_t    strobes,
  input  logic [AW-1:0] flushAddr,
  input  logic [CW-1:0] pendingCnt,
  input  logic [DW-1:0] memRspData,
  output logic [AW-1:0] memReqAddr,
  output logic [DW-1:0] byteData
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

  logic [DW-1:0] slots [DEPTH];
  logic [IW-1:0] wrIdx;
  logic [IW-1:0] rdIdx;
  logic [AW-1:0] fetchPtr;

  function automatic logic [IW-1:0] stepIdx(input logic [IW-1:0] idx);
    return (idx == LAST_IDX) ? '0 : idx + IW'(1);
  endfunction

  // One register per slot; only the tail slot loads on a push.
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slots[g] <= '0;
      end else if (strobes.push && (wrIdx == IW'(g))) begin
        slots[g] <= memRspData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx    <= '0;
      rdIdx    <= '0;
      fetchPtr <= '0;
    end else if (strobes.flush) begin
      wrIdx    <= '0;
      rdIdx    <= '0;
      fetchPtr <= flushAddr;
    end else begin
      if (strobes.push) begin
        wrIdx    <= stepIdx(wrIdx);
        fetchPtr <= fetchPtr + AW'(1);
      end
      if (strobes.pop) begin
        rdIdx <= stepIdx(rdIdx);
      end
    end
  end

  assign memReqAddr = fetchPtr + AW'(pendingCnt);
  assign byteData   = slots[rdIdx];

endmodule

// File: rtl/instr_prefetch_queue.sv
module instr_prefetch_queue
  import prefetch_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushValid,
  input  logic [ADDR_W-1:0] flushAddr,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic              byteValid,
  input  logic              byteReady,
  output logic [DATA_W-1:0] byteData
);

  localparam int CW = $clog2(DEPTH + 1);

  pfStrobes_t    strobes;
  logic [CW-1:0] pendingCnt;

  prefetch_ctrl #(.DEPTH(DEPTH), .CW(CW)) ctrlU (
    .clk        (clk),
    .rstN       (rstN),
    .flushValid (flushValid),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .byteReady  (byteReady),
    .memReqValid(memReqValid),
    .byteValid  (byteValid),
    .pendingCnt (pendingCnt),
    .strobes    (strobes)
  );

  prefetch_dpath #(.DEPTH(DEPTH), .AW(ADDR_W), .DW(DATA_W), .CW(CW)) dpathU (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .flushAddr  (flushAddr),
    .pendingCnt (pendingCnt),
    .memRspData (memRspData),
    .memReqAddr (memReqAddr),
    .byteData   (byteData)
  );

endmodule

// File: rtl/prefetch_queue_checker.sv
module prefetch_queue_checker #(
  parameter int DEPTH = 6,
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          flushValid,
  input logic [AW-1:0] flushAddr,
  input logic          memReqValid,
  input logic          memReqReady,
  input logic [AW-1:0] memReqAddr,
  input logic          byteValid,
  input logic          byteReady,
  input logic [DW-1:0] byteData,
  input logic [CW-1:0] pendingCnt
);

  // R10: no read is presented in a flush cycle
  assert_no_fetch_on_flush_R10: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> !memReqValid);

  // R8: queue is empty the cycle after a flush
  assert_empty_after_flush_R8: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> !byteValid);

  // R8: fetching restarts at the flush target
  assert_flush_target_R8: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> (memReqAddr == $past(flushAddr)));

  // R5: a stalled head byte is held
  assert_head_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !byteReady && !flushValid) |=> (byteValid && $stable(byteData)));

  // R7: consecutive accepted requests step by one address, with wrap
  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady && !flushValid) |=>
      (!memReqValid || (memReqAddr == $past(memReqAddr) + AW'(1))));

  // R6: live reads in flight never exceed the queue size
  assert_pending_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    pendingCnt <= CW'(DEPTH));

endmodule

bind instr_prefetch_queue prefetch_queue_checker #(
  .DEPTH(DEPTH), .AW(ADDR_W), .DW(DATA_W), .CW(CW)
) chkU (
  .clk        (clk),
  .rstN       (rstN),
  .flushValid (flushValid),
  .flushAddr  (flushAddr),
  .memReqValid(memReqValid),
  .memReqReady(memReqReady),
  .memReqAddr (memReqAddr),
  .byteValid  (byteValid),
  .byteReady  (byteReady),
  .byteData   (byteData),
  .pendingCnt (pendingCnt)
);

// File: tb/instr_prefetch_queue_test.sv
module instr_prefetch_queue_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flushValid = 1'b0;
  logic [15:0] flushAddr = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [15:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [7:0]  memRspData = '0;
  logic        byteValid;
  logic        byteReady = 1'b0;
  logic [7:0]  byteData;

  instr_prefetch_queue uut (
    .clk(clk), .rstN(rstN), .flushValid(flushValid), .flushAddr(flushAddr),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .byteValid(byteValid), .byteReady(byteReady), .byteData(byteData)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // stimulus controls
  int lat = 1;          // memory latency in cycles
  int readyMode = 0;    // 0: always ready, 1: stall every third cycle
  int consMode = 0;     // 0: always, 1: never, 2: every other cycle
  bit flushReq = 0;
  logic [15:0] flushTarget = '0;

  // bench model
  int cyc = 0;
  int held = 0;
  int delivered = 0;
  int epoch = 0;
  logic [15:0] expAddr = '0;
  logic [15:0] expReqAddr = '0;
  logic [15:0] memAddr [16];
  int memEpoch [16];
  int memCyc [16];
  int memHead = 0;
  int memTail = 0;
  int memCnt = 0;
  bit afterFlush = 0;
  bit prevStall = 0;
  logic [7:0] prevData = '0;
  bit firstSample = 1;

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return (a[7:0] * 8'd5) ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Driver at the falling edge, monitor 1 ns before the rising edge.
  always begin
    @(negedge clk);
    flushValid = flushReq;
    flushAddr  = flushTarget;
    flushReq   = 0;
    memReqReady = (readyMode == 0) ? 1'b1 : ((cyc % 3) != 0);
    byteReady   = (consMode == 0) ? 1'b1 : (consMode == 1) ? 1'b0 : ((cyc % 2) == 0);
    memRspValid = (memCnt > 0) && (cyc >= memCyc[memHead] + lat);
    memRspData  = memByte(memAddr[memHead]);
    #9;
    if (rstN) begin : sample
      int heldPre;
      int memPre;
      heldPre = held;
      memPre  = memCnt;
      if (firstSample) begin
        check(!byteValid, "R1 byteValid after reset", int'(byteValid), 0);
        check(memReqValid && memReqAddr == 16'h0000, "R1 first request",
              int'(memReqAddr), 0);
        firstSample = 0;
      end
      check(byteValid == (heldPre != 0), "R9 byteValid vs fill", int'(byteValid),
            int'(heldPre != 0));
      if (prevStall)
        check(byteValid && byteData == prevData, "R5 stalled head held",
              int'(byteData), int'(prevData));
      if (afterFlush)
        check(!byteValid, "R8 empty after flush", int'(byteValid), 0);
      if (byteValid && byteReady) begin
        check(byteData == memByte(expAddr), flushValid ? "R10 byte in flush cycle" : "R3 byte order",
              int'(byteData), int'(memByte(expAddr)));
        expAddr = expAddr + 16'd1;
        held = held - 1;
        delivered++;
      end
      if (memRspValid) begin
        if (memEpoch[memHead] == epoch && !flushValid) held = held + 1;
        memHead = (memHead + 1) % 16;
        memCnt--;
      end
      if (flushValid)
        check(!memReqValid, "R10 no request in flush cycle", int'(memReqValid), 0);
      if (memReqValid) begin
        check(heldPre + memPre < 6, "R6 slot reservation", heldPre + memPre, 5);
        check(memReqAddr == expReqAddr, "R7 request address", int'(memReqAddr),
              int'(expReqAddr));
        if (memReqReady) begin
          memAddr[memTail]  = memReqAddr;
          memEpoch[memTail] = epoch;
          memCyc[memTail]   = cyc;
          memTail = (memTail + 1) % 16;
          memCnt++;
          expReqAddr = expReqAddr + 16'd1;
        end
      end
      if (flushValid) begin
        epoch++;
        held = 0;
        expAddr = flushAddr;
        expReqAddr = flushAddr;
      end
      afterFlush = flushValid;
      prevStall = byteValid && !byteReady && !flushValid;
      prevData = byteData;
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 150000", cyc);
        finishRun();
      end
    end
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
    #5;
  endtask

  task automatic doFlush(input logic [15:0] t);
    flushTarget = t;
    flushReq = 1;
    waitCycles(1);
  endtask

  initial begin
    int startCnt;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R2: consumer stalled, queue fills to six and stops fetching
    consMode = 1; lat = 1; readyMode = 0;
    waitCycles(30);
    check(byteValid && !memReqValid && held == 6, "R2 full at six", held, 6);
    check(!memReqValid, "R2 no fetch while full", int'(memReqValid), 0);
    consMode = 0;
    waitCycles(20);

    // R4: concurrent fetch and drain at full rate
    startCnt = delivered;
    waitCycles(50);
    check(delivered - startCnt >= 46, "R4 throughput", delivered - startCnt, 46);

    // R7: wrap of the fetch pointer
    doFlush(16'hFFFD);
    waitCycles(20);
    check(expAddr > 16'h0003 && expAddr < 16'h0100, "R7 wrap past 0xFFFF",
          int'(expAddr), 4);

    // R8: flush while slow responses are in flight
    lat = 4;
    waitCycles(10);
    doFlush(16'h1234);
    waitCycles(30);
    check(expAddr > 16'h1234, "R8 resumed at target", int'(expAddr), 16'h1235);

    // near-exhaustive sweep of latency, memory ready and consumer patterns
    for (int l = 1; l <= 4; l++) begin
      for (int r = 0; r < 2; r++) begin
        for (int c = 0; c < 3; c++) begin
          lat = l; readyMode = r; consMode = c;
          waitCycles(17);
          doFlush(16'hFFF8 + 16'(l * 7 + r * 3 + c));
          waitCycles(23);
        end
      end
    end
    consMode = 0; readyMode = 0; lat = 1;
    waitCycles(20);
    finishRun();
  end

endmodule